// File: doc/BRIEF.md
# Instruction Word Format Classifier

This block looks at one 32-bit instruction word on its own and tells the decoder which kind of word it is. The word can be a pair of 16-bit short instructions or a specialized pair. It can be a short instruction followed by a prefix for the next instruction, or by a shift or relative branch. It can be a prefix that covers the next fetch block, the first word of a long string instruction, or a word that needs some other decoder. The class does not come from an opcode field. It comes from field combinations that would otherwise be illegal: equal register fields, a leading opcode pair of 11, or both condition-code bits set.

The block also pulls out the payload the word carries. For an instruction prefix this is the zero-extended prefix bits and their width. For a block prefix it is the 8-bit per-word mask and its 4-bit sub-opcode. The block has no clock and no state. A 256-bit fetch block therefore places eight copies next to each other, and all eight words are classified in the same cycle.

Bit 31 is the first bit of the word. The upper half (bits 31:16) holds the leading short instruction:

| Bits | Field |
|---|---|
| 31:30 | lead |
| 29:23 | opcode (29:28 are the leading opcode bits) |
| 22 | cc |
| 21:19 | dst |
| 18:16 | src |

A lower-half short instruction uses the same layout one half lower:

| Bits | Field |
|---|---|
| 15:14 | tag |
| 13:7 | opcode |
| 6 | cc |
| 5:3 | dst |
| 2:0 | src |

Top module: `instr_word_classifier`

## Requirements
- R1: When bits 31:30 are not 11, the class output is other (class bit 7). The prefix-valid flag, the prefix-width flag, the prefix payload, the block mask and the block sub-opcode are all zero.
- R2: When bits 31:28 are 1111, the class is long-instruction head (bit 5). This holds whatever the rest of the word contains, including equal register fields.
- R3: When bits 31:30 are 11, bits 29:28 are not 11, and the upper dst field (21:19) equals the upper src field (18:16), the class is specialized word (bit 6).
- R4: A valid leading short instruction followed by a lower half with tag 00 is a short pair (bit 0), provided three things hold. The lower opcode bits 13:12 are not 11. The lower dst (5:3) differs from the lower src (2:0). The two cc bits 22 and 6 are not both 1.
- R5: The same word as in R4, but with both cc bits 22 and 6 set, is a specialized pair (bit 1).
- R6: A lower half whose bits 15:13 are 000 and whose bits 5:0 are all zero is a narrow instruction prefix (bit 2). The prefix-valid flag is 1, the width flag is 0, and the payload is bits 12:6 zero-extended to 12 bits.
- R7: A lower half whose bits 15:12 are 1000 is a wide instruction prefix (bit 2). The prefix-valid flag is 1, the width flag is 1, and the payload is bits 11:0.
- R8: A lower half with tag 01 and bits 13:12 not equal to 11 is a shift or relative-branch half (bit 3).
- R9: A lower half with bits 15:12 equal to 0111 is a block prefix (bit 4). The block mask is bits 7:0 and the block sub-opcode is bits 11:8.
- R10: After a valid leading short instruction, each of the following lower halves makes the class other (bit 7):
  - tag 11;
  - tag 10 with bits 13:12 not equal to 00;
  - tag 00, not a narrow prefix, with lower opcode bits 13:12 equal to 11;
  - tag 00, not a narrow prefix, with the lower dst equal to the lower src.
- R11: Exactly one class bit is set for every word. The prefix outputs are zero unless the class is instruction prefix, and the block outputs are zero unless the class is block prefix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instrWord | input | 32 | Instruction word to classify, bit 31 first |
| wordClass | output | 8 | One-hot class, bit positions as in R1 to R10 |
| pfxValid | output | 1 | Word carries an instruction prefix |
| pfxWide | output | 1 | Prefix is 12 bits wide (0 means 7 bits) |
| pfxPayload | output | 12 | Zero-extended prefix bits |
| blockMask | output | 8 | Per-word mask of a block prefix |
| blockOp | output | 4 | Sub-opcode of a block prefix |

## Verification
The bench builds the block with its package defaults: a 32-bit word, 3-bit register fields, 7- and 12-bit prefix payloads and an 8-bit block mask. These are the only widths at which the field positions are defined. About half of the random words are forced to start with 11 so that the lower-half decode is reached often. Directed words cover the cases random stimulus rarely hits: equal register fields, both cc bits set, the all-zero prefix registers, and the reserved lower-half tags.

// File: rtl/iwc_pkg.sv
package iwc_pkg;
  localparam int WORD_W   = 32;
  localparam int HALF_W   = WORD_W / 2;
  localparam int REG_W    = 3;
  localparam int NARROW_W = 7;
  localparam int WIDE_W   = 12;
  localparam int MASK_W   = 8;
  localparam int BOP_W    = 4;
  localparam int NUM_CLS  = 8;

  // upper-half field positions
  localparam int LEAD_MSB = WORD_W - 1;
  localparam int UCC_POS  = HALF_W + 2 * REG_W;
  localparam int UDST_LSB = HALF_W + REG_W;
  localparam int USRC_LSB = HALF_W;
  // lower-half field positions
  localparam int LTAG_MSB = HALF_W - 1;
  localparam int LCC_POS  = 2 * REG_W;
  localparam int LDST_LSB = REG_W;
  localparam int NARROW_LSB = 2 * REG_W;

  // class bit indices
  localparam int CL_PAIR     = 0;
  localparam int CL_SPECPAIR = 1;
  localparam int CL_PREFIX   = 2;
  localparam int CL_ALT      = 3;
  localparam int CL_BLOCK    = 4;
  localparam int CL_LONG     = 5;
  localparam int CL_SPECWORD = 6;
  localparam int CL_OTHER    = 7;

  typedef struct packed {
    logic takeNarrow;
    logic takeWide;
    logic takeBlock;
  } dpStrobe_t;
endpackage

// File: rtl/iwc_ctrl.sv
module iwc_ctrl
  import iwc_pkg::*;
(
  input  logic [WORD_W-1:0]  instrWord,
  output logic [NUM_CLS-1:0] wordClass,
  output dpStrobe_t          stb
);
  logic [1:0]       lead, leadOp, lowTag, lowOp;
  logic [REG_W-1:0] dstHi, srcHi, dstLo, srcLo;
  logic             ccHi, ccLo, lowThird;

  assign lead     = instrWord[LEAD_MSB -: 2];
  assign leadOp   = instrWord[LEAD_MSB-2 -: 2];
  assign ccHi     = instrWord[UCC_POS];
  assign dstHi    = instrWord[UDST_LSB +: REG_W];
  assign srcHi    = instrWord[USRC_LSB +: REG_W];
  assign lowTag   = instrWord[LTAG_MSB -: 2];
  assign lowOp    = instrWord[LTAG_MSB-2 -: 2];
  assign lowThird = instrWord[LTAG_MSB-2];
  assign ccLo     = instrWord[LCC_POS];
  assign dstLo    = instrWord[LDST_LSB +: REG_W];
  assign srcLo    = instrWord[0 +: REG_W];

  logic [NUM_CLS-1:0] cls;
  dpStrobe_t          st;

  always_comb begin
    cls = '0;
    st  = '0;
    if (lead != 2'b11) begin
      cls[CL_OTHER] = 1'b1;
    end else if (leadOp == 2'b11) begin
      cls[CL_LONG] = 1'b1;
    end else if (dstHi == srcHi) begin
      cls[CL_SPECWORD] = 1'b1;
    end else begin
      unique case (lowTag)
        2'b00: begin
          if (!lowThird && dstLo == '0 && srcLo == '0) begin
            cls[CL_PREFIX] = 1'b1;
            st.takeNarrow  = 1'b1;
          end else if (lowOp == 2'b11 || dstLo == srcLo) begin
            cls[CL_OTHER] = 1'b1;
          end else if (ccHi && ccLo) begin
            cls[CL_SPECPAIR] = 1'b1;
          end else begin
            cls[CL_PAIR] = 1'b1;
          end
        end
        2'b01: begin
          if (lowOp == 2'b11) begin
            cls[CL_BLOCK] = 1'b1;
            st.takeBlock  = 1'b1;
          end else begin
            cls[CL_ALT] = 1'b1;
          end
        end
        2'b10: begin
          if (lowOp == 2'b00) begin
            cls[CL_PREFIX] = 1'b1;
            st.takeWide    = 1'b1;
          end else begin
            cls[CL_OTHER] = 1'b1;
          end
        end
        default: cls[CL_OTHER] = 1'b1;
      endcase
    end
    wordClass = cls;
    stb       = st;

    AST_ONE_CLASS: assert ($onehot(cls)) else $error("class not one-hot"); // R11
    AST_STROBE_EXCL: assert ($countones({st.takeNarrow, st.takeWide, st.takeBlock}) <= 1)
      else $error("strobes overlap"); // R11
    AST_STROBE_CLASS: assert ((st.takeNarrow || st.takeWide) == cls[CL_PREFIX])
      else $error("prefix strobe disagrees with class"); // R6
  end
endmodule

// File: rtl/iwc_dp.sv
module iwc_dp
  import iwc_pkg::*;
(
  input  logic [WORD_W-1:0] instrWord,
  input  dpStrobe_t         stb,
  output logic              pfxValid,
  output logic              pfxWide,
  output logic [WIDE_W-1:0] pfxPayload,
  output logic [MASK_W-1:0] blockMask,
  output logic [BOP_W-1:0]  blockOp
);
  logic [NARROW_W-1:0] narrowBits;
  logic [WIDE_W-1:0]   wideBits;

  assign narrowBits = instrWord[NARROW_LSB +: NARROW_W];
  assign wideBits   = instrWord[0 +: WIDE_W];

  logic [WIDE_W-1:0] pay;
  logic [MASK_W-1:0] msk;
  logic [BOP_W-1:0]  bop;

  always_comb begin
    pay = '0;
    msk = '0;
    bop = '0;
    if (stb.takeNarrow) pay = {{(WIDE_W-NARROW_W){1'b0}}, narrowBits};
    else if (stb.takeWide) pay = wideBits;
    if (stb.takeBlock) begin
      msk = instrWord[0 +: MASK_W];
      bop = instrWord[MASK_W +: BOP_W];
    end
    pfxValid   = stb.takeNarrow | stb.takeWide;
    pfxWide    = stb.takeWide;
    pfxPayload = pay;
    blockMask  = msk;
    blockOp    = bop;

    AST_NARROW_FITS: assert (!stb.takeNarrow || pay[WIDE_W-1:NARROW_W] == '0)
      else $error("narrow payload spills"); // R6
    AST_PFX_QUIET: assert (stb.takeNarrow || stb.takeWide || pay == '0)
      else $error("payload without prefix"); // R11
    AST_BLOCK_QUIET: assert (stb.takeBlock || (msk == '0 && bop == '0))
      else $error("block fields without block prefix"); // R9
  end
endmodule

// File: rtl/instr_word_classifier.sv
module instr_word_classifier
  import iwc_pkg::*;
(
  input  logic [31:0] instrWord,
  output logic [7:0]  wordClass,
  output logic        pfxValid,
  output logic        pfxWide,
  output logic [11:0] pfxPayload,
  output logic [7:0]  blockMask,
  output logic [3:0]  blockOp
);
  dpStrobe_t stb;

  iwc_ctrl ctrl_i (
    .instrWord (instrWord),
    .wordClass (wordClass),
    .stb       (stb)
  );

  iwc_dp dp_i (
    .instrWord  (instrWord),
    .stb        (stb),
    .pfxValid   (pfxValid),
    .pfxWide    (pfxWide),
    .pfxPayload (pfxPayload),
    .blockMask  (blockMask),
    .blockOp    (blockOp)
  );
endmodule

// File: tb/instr_word_classifier_tb.sv
module instr_word_classifier_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [31:0] instrWord = '0;
  logic [7:0]  wordClass;
  logic        pfxValid, pfxWide;
  logic [11:0] pfxPayload;
  logic [7:0]  blockMask;
  logic [3:0]  blockOp;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  instr_word_classifier dut_i (
    .instrWord(instrWord), .wordClass(wordClass), .pfxValid(pfxValid),
    .pfxWide(pfxWide), .pfxPayload(pfxPayload), .blockMask(blockMask),
    .blockOp(blockOp)
  );

  // expected {class, valid, wide, payload, mask, op} = 8+1+1+12+8+4 = 34 bits
  function automatic logic [33:0] model(input logic [31:0] w, output string tag);
    logic [7:0] c; logic v, wd; logic [11:0] p; logic [7:0] m; logic [3:0] o;
    logic [15:0] lo;
    c = 0; v = 0; wd = 0; p = 0; m = 0; o = 0; lo = w[15:0];
    if (w[31] !== 1'b1 || w[30] !== 1'b1) begin c = 8'h80; tag = "R1"; end
    else if (w[29] && w[28]) begin c = 8'h20; tag = "R2"; end
    else if (w[21:19] == w[18:16]) begin c = 8'h40; tag = "R3"; end
    else if (lo[15:13] == 3'b000 && lo[5:0] == 6'd0) begin
      c = 8'h04; v = 1; p = {5'd0, lo[12:6]}; tag = "R6";
    end else if (lo[15:12] == 4'b1000) begin
      c = 8'h04; v = 1; wd = 1; p = lo[11:0]; tag = "R7";
    end else if (lo[15:12] == 4'b0111) begin
      c = 8'h10; m = lo[7:0]; o = lo[11:8]; tag = "R9";
    end else if (lo[15:14] == 2'b01) begin c = 8'h08; tag = "R8"; end
    else if (lo[15:14] != 2'b00 || lo[13:12] == 2'b11 || lo[5:3] == lo[2:0]) begin
      c = 8'h80; tag = "R10";
    end else if (w[22] && lo[6]) begin c = 8'h02; tag = "R5"; end
    else begin c = 8'h01; tag = "R4"; end
    return {c, v, wd, p, m, o};
  endfunction

  task automatic check(input logic [31:0] w);
    logic [33:0] exp, act; string tag;
    @(negedge clk);
    instrWord = w;
    #1;
    exp = model(w, tag);
    act = {wordClass, pfxValid, pfxWide, pfxPayload, blockMask, blockOp};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s word=%h actual=%h expected=%h", tag, w, act, exp);
    end
    // R11 one-hot class at the ports
    checks++;
    if ($countones(wordClass) != 1) begin
      errors++;
      $display("FAIL R11 word=%h actual class=%b expected one-hot", w, wordClass);
    end
  endtask

  function automatic logic [15:0] hiShort(input logic cc, input logic [2:0] d, input logic [2:0] s);
    return {2'b11, 7'h15, cc, d, s};
  endfunction
  function automatic logic [15:0] loShort(input logic [1:0] op2, input logic cc,
                                          input logic [2:0] d, input logic [2:0] s);
    return {2'b00, op2, 5'h0b, cc, d, s};
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    rst = 1'b0;
    check(32'h0000_0000);                                        // R1 reset state
    check(32'h7fff_ffff);                                        // R1
    check(32'hF000_0000);                                        // R2 equal regs ignored
    check(32'hFA5A_1234);                                        // R2
    check({hiShort(1'b0, 3'd2, 3'd2), loShort(2'b01, 1'b0, 3'd1, 3'd3)}); // R3
    check({hiShort(1'b0, 3'd1, 3'd2), loShort(2'b01, 1'b0, 3'd3, 3'd4)}); // R4
    check({hiShort(1'b1, 3'd1, 3'd2), loShort(2'b10, 1'b0, 3'd3, 3'd4)}); // R4 one cc
    check({hiShort(1'b1, 3'd1, 3'd2), loShort(2'b01, 1'b1, 3'd3, 3'd4)}); // R5
    check({hiShort(1'b0, 3'd1, 3'd2), 3'b000, 7'h5A, 6'd0});             // R6
    check({hiShort(1'b1, 3'd1, 3'd2), 3'b000, 7'h7F, 6'd0});             // R6
    check({hiShort(1'b0, 3'd1, 3'd2), 4'b1000, 12'hABC});                // R7
    check({hiShort(1'b0, 3'd5, 3'd2), 4'b0110, 12'h123});                // R8
    check({hiShort(1'b0, 3'd5, 3'd2), 4'b0100, 12'hFFF});                // R8
    check({hiShort(1'b0, 3'd5, 3'd2), 4'b0111, 4'h9, 8'hA5});            // R9
    check({hiShort(1'b0, 3'd1, 3'd2), 4'b1100, 12'h000});                // R10 tag 11
    check({hiShort(1'b0, 3'd1, 3'd2), 4'b1001, 12'h777});                // R10 tag 10
    check({hiShort(1'b0, 3'd1, 3'd2), loShort(2'b11, 1'b0, 3'd3, 3'd4)}); // R10 op 11
    check({hiShort(1'b0, 3'd1, 3'd2), loShort(2'b01, 1'b0, 3'd5, 3'd5)}); // R10 equal regs
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] w;
      w = $urandom;
      if (i % 2 == 0) w[31:30] = 2'b11;
      check(w);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule